// File: doc/BRIEF.md
# Reload down-counter timer

A memory-mapped timer block with a parameterised number of 32-bit channels (three by default). Every channel counts down at its input clock divided by a selectable prescale. When a channel steps past zero it reloads from its own constant register, raises a sticky underflow flag and, if enabled, drives its interrupt output high. Software starts and halts all channels through one shared 8-bit start register and reads a channel's count at any time. The bitwise inverse of a count gives a rising free-running time base.

The register port is a plain word bus: byte address, write strobe, four byte enables, write data and read data. Read data is registered and appears one cycle after the address. Software typically halts a channel, loads its constant and count, sets the control word and then sets the channel's run bit. An interrupt is acknowledged by rewriting the control word with bit 8 cleared. Bit 5 of that write decides whether the interrupt stays enabled.

Top module: `reload_timer`

## Requirements
- R1: After reset the start register, every control register and every interrupt output are 0, and every constant and count register reads 0xFFFFFFFF.
- R2: The start register is byte address 0, bits 7:0, written through lane 0. Bit n set makes channel n count. Bit n clear halts channel n, and its count holds its value. The register reads back as written.
- R3: Channel n's registers start at byte 4 + 12*n: constant at +0, count at +4, control at +8. Each byte enable writes only its lane. Read data appears on the cycle after the address. Unmapped word addresses read 0. Accesses with address bits 1:0 not 00 are ignored.
- R4: Control bits 2:0 select the prescale: 000 divides by 4, 001 by 16, 010 by 64, 011 and every code with bit 2 set by 256. A running channel steps once per prescale period. The first step falls on the D-th rising edge after the edge that sets its run bit, where D is the divisor.
- R5: A halted channel's prescale counter returns to zero, so partial progress made before a halt is lost.
- R6: A step taken while the count is 0 loads the constant into the count and sets the underflow flag, which reads at control bit 8.
- R7: A control write with lane 1 enabled and bit 8 = 0 clears the flag. A write with bit 8 = 1, or with lane 1 disabled, leaves the flag unchanged. Lane 0 writes bits 2:0 and the interrupt enable at bit 5.
- R8: Each channel's interrupt output equals its flag AND its enable bit 5. It changes on the same edge as those bits.
- R9: When an underflow and a flag-clearing control write fall on the same edge, the flag ends up set.
- R10: When a software write to the count and a prescale step fall on the same edge, the written value is kept and the step is dropped.
- R11: Constant and count values written while a channel is halted are the values it starts from when it next runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| we | input | 1 | Write strobe |
| be | input | DATA_W/8 | Byte-lane enables for writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
Two of the block's actions can fall on the same edge: the hardware setting a flag on underflow and software clearing it, and a prescale step and a software write to the count. The bench counts edges from the edge that starts a channel. It places the control write or the count write on exactly the fourth edge, where a divide-by-4 channel takes its first step. Afterwards it halts the channel and reads the registers back. A flag that is still set with its interrupt high, and a count equal to the written value, show that the intended side won.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CTRL_W   = 16;
  localparam int SEL_W    = 3;
  localparam int IE_BIT   = 5;
  localparam int FLAG_BIT = 8;
  localparam int PS_W     = 8;

  // Terminal value of the prescale counter for a select code.
  function automatic logic [PS_W-1:0] ps_limit(input logic [SEL_W-1:0] sel);
    logic [PS_W-1:0] lim;
    if (sel[2]) lim = 8'd255;
    else begin
      case (sel[1:0])
        2'd0:    lim = 8'd3;
        2'd1:    lim = 8'd15;
        2'd2:    lim = 8'd63;
        default: lim = 8'd255;
      endcase
    end
    return lim;
  endfunction
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PS_W-1:0] pcnt_q;

  assign tick = run && (pcnt_q == ps_limit(sel));

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt_q <= '0;
    else if (tick)   pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int BE_W = CNT_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_const,
  input  logic              wr_cnt,
  input  logic              wr_ctrl,
  input  logic [BE_W-1:0]   be,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  const_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              flag_o,
  output logic              ie_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] const_q, cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q, ie_d, flag_d, tick, under;

  timer_prescaler u_ps (.clk(clk), .rst(rst), .run(run), .sel(sel_q), .tick(tick));

  function automatic logic [CNT_W-1:0] lanes(input logic [CNT_W-1:0] old_v,
                                             input logic [CNT_W-1:0] new_v,
                                             input logic [BE_W-1:0]  en);
    logic [CNT_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++)
      if (en[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  // A count write on the same edge cancels the step (and its underflow).
  assign under = tick && (cnt_q == '0) && !wr_cnt;

  always_comb begin
    ie_d = ie_q;
    if (wr_ctrl && be[0]) ie_d = wdata[IE_BIT];
    flag_d = flag_q;
    if (wr_ctrl && be[1] && !wdata[FLAG_BIT]) flag_d = 1'b0;
    if (under) flag_d = 1'b1;   // hardware set wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      const_q <= '1;
      cnt_q   <= '1;
      sel_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (wr_const) const_q <= lanes(const_q, wdata, be);
      if (wr_cnt)        cnt_q <= lanes(cnt_q, wdata, be);
      else if (under)    cnt_q <= const_q;
      else if (tick)     cnt_q <= cnt_q - 1'b1;
      if (wr_ctrl && be[0]) sel_q <= wdata[SEL_W-1:0];
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq_o  <= ie_d && flag_d;
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[SEL_W-1:0] = sel_q;
    ctrl_o[IE_BIT]    = ie_q;
    ctrl_o[FLAG_BIT]  = flag_q;
  end

  assign const_o = const_q;
  assign cnt_o   = cnt_q;
  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int START_W = 8,
  parameter int ADDR_W  = 8,
  localparam int BE_W   = DATA_W / 8,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [START_W-1:0] start_q;
  logic [WORD_W-1:0]  waddr;
  logic               aligned;
  logic [NUM_CH-1:0]  wr_const_v, wr_cnt_v, wr_ctrl_v, clr_v, flag_v, ie_v, run_v;
  logic [NUM_CH-1:0][CNT_W-1:0]  const_v, cnt_v;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_v;
  logic [DATA_W-1:0]  rd_next;

  assign waddr   = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign run_v   = start_q[NUM_CH-1:0];

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else if (we && aligned && be[0] && waddr == '0) start_q <= wdata[START_W-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = 1 + 3 * c;
    assign wr_const_v[c] = we && aligned && (waddr == WORD_W'(BASE));
    assign wr_cnt_v[c]   = we && aligned && (waddr == WORD_W'(BASE + 1));
    assign wr_ctrl_v[c]  = we && aligned && (waddr == WORD_W'(BASE + 2));
    assign clr_v[c]      = wr_ctrl_v[c] && be[1] && !wdata[FLAG_BIT];

    timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run(run_v[c]),
      .wr_const(wr_const_v[c]), .wr_cnt(wr_cnt_v[c]), .wr_ctrl(wr_ctrl_v[c]),
      .be(be), .wdata(wdata[CNT_W-1:0]),
      .const_o(const_v[c]), .cnt_o(cnt_v[c]), .ctrl_o(ctrl_v[c]),
      .flag_o(flag_v[c]), .ie_o(ie_v[c]), .irq_o(irq[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (waddr == '0) rd_next[START_W-1:0] = start_q;
      for (int c = 0; c < NUM_CH; c++) begin
        if (waddr == WORD_W'(1 + 3 * c)) rd_next[CNT_W-1:0]  = const_v[c];
        if (waddr == WORD_W'(2 + 3 * c)) rd_next[CNT_W-1:0]  = cnt_v[c];
        if (waddr == WORD_W'(3 + 3 * c)) rd_next[CTRL_W-1:0] = ctrl_v[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
) (
  input logic clk,
  input logic rst,
  input logic [NUM_CH-1:0] run_v,
  input logic [NUM_CH-1:0] wr_cnt_v,
  input logic [NUM_CH-1:0] wr_const_v,
  input logic [NUM_CH-1:0] clr_v,
  input logic [NUM_CH-1:0] flag_v,
  input logic [NUM_CH-1:0] ie_v,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_CH-1:0][CNT_W-1:0] const_v
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (rst)
      (!run_v[c] && !wr_cnt_v[c]) |=> $stable(cnt_v[c]));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
      (run_v[c] && !wr_cnt_v[c] && cnt_v[c] != '0) |=>
        (cnt_v[c] == $past(cnt_v[c]) || cnt_v[c] == $past(cnt_v[c]) - 1'b1));

    assert_zero_reloads_R6: assert property (@(posedge clk) disable iff (rst)
      (run_v[c] && !wr_cnt_v[c] && cnt_v[c] == '0) |=>
        (cnt_v[c] == '0 || cnt_v[c] == $past(const_v[c])));

    assert_flag_source_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_v[c]) |-> $past(run_v[c] && cnt_v[c] == '0 && !wr_cnt_v[c]));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (flag_v[c] && !clr_v[c]) |=> flag_v[c]);

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
      irq[c] == (flag_v[c] && ie_v[c]));

    assert_reload_value_R6: assert property (@(posedge clk) disable iff (rst)
      ($rose(flag_v[c]) && !$past(wr_const_v[c])) |-> cnt_v[c] == const_v[c]);
  end
endmodule

bind reload_timer timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run_v(run_v), .wr_cnt_v(wr_cnt_v),
  .wr_const_v(wr_const_v), .clr_v(clr_v), .flag_v(flag_v), .ie_v(ie_v),
  .irq(irq), .cnt_v(cnt_v), .const_v(const_v)
);

// File: tb/test_reload_timer.sv
module test_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int checks = 0;
  int errors = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .be(be),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [2:0]  sel;
    logic [31:0] cval;
    logic [31:0] cinit;
    logic [31:0] wait_n;
    logic [31:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  // steps = (wait_n + 1) / divisor
  localparam vec_t VECS [7] = '{
    '{2'd0, 3'd0, 32'd100, 32'd50, 32'd39,  32'd40, 1'b0},
    '{2'd1, 3'd1, 32'd100, 32'd5,  32'd63,  32'd1,  1'b0},
    '{2'd2, 3'd0, 32'd9,   32'd2,  32'd23,  32'd6,  1'b1},
    '{2'd0, 3'd2, 32'd7,   32'd0,  32'd127, 32'd6,  1'b1},
    '{2'd1, 3'd3, 32'd3,   32'd1,  32'd255, 32'd0,  1'b0},
    '{2'd2, 3'd0, 32'd0,   32'd0,  32'd11,  32'd0,  1'b1},
    '{2'd2, 3'd5, 32'd10,  32'd4,  32'd511, 32'd2,  1'b0}
  };

  function automatic logic [7:0] a_const(input int ch); return 8'(4 + 12*ch);  endfunction
  function automatic logic [7:0] a_cnt(input int ch);   return 8'(8 + 12*ch);  endfunction
  function automatic logic [7:0] a_ctrl(input int ch);  return 8'(12 + 12*ch); endfunction

  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] v);
    addr = a; be = b; wdata = v; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; we = 1'b0;
    @(posedge clk); @(negedge clk);
    v = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'd0, d);        chk("R1 start", d, 32'h0);
    rd(a_const(1), d);  chk("R1 const", d, 32'hFFFFFFFF);
    rd(a_cnt(2), d);    chk("R1 count", d, 32'hFFFFFFFF);
    rd(a_ctrl(0), d);   chk("R1 ctrl", d, 32'h0);
    chk("R1 irq", {29'd0, irq}, 32'h0);

    // R3 lanes, unmapped and misaligned
    wr(a_cnt(0), 4'b0001, 32'hAABBCCDD);
    rd(a_cnt(0), d);    chk("R3 lane0", d, 32'hFFFFFFDD);
    wr(a_const(0), 4'b1100, 32'h12345678);
    rd(a_const(0), d);  chk("R3 lane32", d, 32'h1234FFFF);
    rd(8'd40, d);       chk("R3 unmapped", d, 32'h0);
    wr(a_const(0) + 8'd1, 4'b1111, 32'h0);
    rd(a_const(0), d);  chk("R3 misaligned", d, 32'h1234FFFF);

    // R2 shared start register readback
    wr(8'd0, 4'b0001, 32'h05);
    rd(8'd0, d);        chk("R2 readback", d, 32'h05);
    wr(8'd0, 4'b0001, 32'h00);

    // Vector table: R4 prescale, R6 reload, R11 preload, R2 hold, R8 gating
    foreach (VECS[i]) begin
      automatic int ch = int'(VECS[i].ch);
      wr(a_ctrl(ch), 4'b0011, {29'd0, VECS[i].sel});
      wr(a_const(ch), 4'b1111, VECS[i].cval);
      wr(a_cnt(ch), 4'b1111, VECS[i].cinit);
      wr(8'd0, 4'b0001, 32'(1 << ch));
      repeat (int'(VECS[i].wait_n)) @(negedge clk);
      wr(8'd0, 4'b0001, 32'h0);
      rd(a_cnt(ch), d);  chk($sformatf("R4 R6 R11 vec%0d count", i), d, VECS[i].exp_cnt);
      rd(a_ctrl(ch), d); chk($sformatf("R6 vec%0d ctrl", i), d,
                             {23'd0, VECS[i].exp_flag, 5'd0, VECS[i].sel});
      chk($sformatf("R8 vec%0d irq off", i), {29'd0, irq}, 32'h0);
      repeat (10) @(negedge clk);
      rd(a_cnt(ch), d);  chk($sformatf("R2 vec%0d hold", i), d, VECS[i].exp_cnt);
    end

    // R5 prescaler restarts after a halt
    wr(a_ctrl(0), 4'b0011, 32'h0);
    wr(a_cnt(0), 4'b1111, 32'd20);
    wr(8'd0, 4'b0001, 32'h1);
    @(negedge clk);
    wr(8'd0, 4'b0001, 32'h0);
    wr(8'd0, 4'b0001, 32'h1);
    @(negedge clk);
    wr(8'd0, 4'b0001, 32'h0);
    rd(a_cnt(0), d);    chk("R5 restart", d, 32'd20);

    // R8 interrupt timing and R7 clearing rules on channel 1
    wr(a_ctrl(1), 4'b0011, 32'h20);
    wr(a_const(1), 4'b1111, 32'd3);
    wr(a_cnt(1), 4'b1111, 32'd0);
    wr(8'd0, 4'b0001, 32'h2);
    repeat (3) @(negedge clk);
    chk("R4 R8 before step", {29'd0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq at underflow", {29'd0, irq}, 32'h2);
    wr(8'd0, 4'b0001, 32'h0);
    wr(a_ctrl(1), 4'b0011, 32'h0120);
    rd(a_ctrl(1), d);   chk("R7 bit8 set keeps", d, 32'h0120);
    wr(a_ctrl(1), 4'b0001, 32'h0020);
    rd(a_ctrl(1), d);   chk("R7 lane1 off keeps", d, 32'h0120);
    chk("R8 still high", {29'd0, irq}, 32'h2);
    wr(a_ctrl(1), 4'b0011, 32'h0020);
    rd(a_ctrl(1), d);   chk("R7 ack keep enable", d, 32'h0020);
    chk("R8 low after ack", {29'd0, irq}, 32'h0);
    wr(8'd0, 4'b0001, 32'h2);
    repeat (40) @(negedge clk);
    wr(8'd0, 4'b0001, 32'h0);
    chk("R8 high again", {29'd0, irq}, 32'h2);
    wr(a_ctrl(1), 4'b0011, 32'h0000);
    rd(a_ctrl(1), d);   chk("R7 ack disable", d, 32'h0);
    chk("R8 low after disable", {29'd0, irq}, 32'h0);

    // R9 underflow and clear on the same edge
    wr(a_const(0), 4'b1111, 32'd5);
    wr(a_cnt(0), 4'b1111, 32'd0);
    wr(a_ctrl(0), 4'b0011, 32'h0020);
    wr(8'd0, 4'b0001, 32'h1);
    repeat (3) @(negedge clk);
    wr(a_ctrl(0), 4'b0011, 32'h0020);
    wr(8'd0, 4'b0001, 32'h0);
    rd(a_ctrl(0), d);   chk("R9 set wins", d, 32'h0120);
    chk("R9 irq", {29'd0, irq}, 32'h1);
    rd(a_cnt(0), d);    chk("R9 reloaded", d, 32'd5);

    // R10 count write and step on the same edge
    wr(a_ctrl(2), 4'b0011, 32'h0);
    wr(a_cnt(2), 4'b1111, 32'd50);
    wr(8'd0, 4'b0001, 32'h4);
    repeat (3) @(negedge clk);
    wr(a_cnt(2), 4'b1111, 32'd1000);
    wr(8'd0, 4'b0001, 32'h0);
    rd(a_cnt(2), d);    chk("R10 write wins", d, 32'd1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule